// File: doc/BRIEF.md
# Multiplexed Keypad Matrix Register

This block is a memory-mapped register for an eight-button keypad. The buttons form two groups of four: an action group (Start, Select, B, A) and a direction group (Down, Up, Left, Right). The button inputs are active-high. Software writes two active-low select bits to choose which groups are scanned. It then reads back a 4-bit nibble in which a 0 means "pressed". When both groups are selected, their results are AND-combined.

The direction pad is a rocker, so it cannot show opposing directions pressed together. By default the block enforces this: Up masks Down, and Left masks Right. A mode input turns the masking off, for hosts that drive such combinations on purpose.

When neither group is selected, the nibble carries an idle value. That value is 0xF minus a small controller-request number. The block also raises a one-cycle interrupt pulse each time the scanned nibble leaves the all-released value 0xF.

Top module: `keypad_matrix_reg`

## Requirements
- R1: A synchronous active-high reset sets both select bits to 1 and the `irq` output to 0. A read of 0xFF00 after reset, with the controller-request input at 0, returns 0xFF.
- R2: A read of address 0xFF00 (`rd_en` high) updates `rd_data` on the next clock edge. The bit layout is:
  - bits [7:6] are 1;
  - bit 5 is the action-select bit and bit 4 is the direction-select bit;
  - bits [3:0] are the scanned nibble at the cycle of the read.
- R3: A write to 0xFF00 stores only data bits 5 and 4 as the select bits. All other data bits have no effect.
- R4: When bit 5 is 0, each pressed action key clears its nibble bit. The bit positions are Start=3, Select=2, B=1, A=0. When bit 5 is 1, the action keys have no effect.
- R5: When bit 4 is 0, each pressed direction key clears its nibble bit. The bit positions are Down=3, Up=2, Left=1, Right=0. When bit 4 is 1, the direction keys have no effect.
- R6: When both select bits are 0, the nibble is the bitwise AND of the two groups' active-low results.
- R7: When `allow_opposing` is 0, a pressed Up makes Down read as released, and a pressed Left makes Right read as released.
- R8: When `allow_opposing` is 1, no direction is masked.
- R9: When both select bits are 1, the nibble is 0xF minus `ctrl_req`, saturating at 0. The keys have no effect.
- R10: `irq` is high for exactly one cycle. It rises on the clock edge after the scanned nibble changes from 0xF to any other value. A held key does not fire it again.
- R11: A read of any address other than 0xFF00 returns 0xFF. A write to any other address leaves the select bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| act_keys | input | 4 | Action buttons, active-high (Start, Select, B, A) |
| dir_keys | input | 4 | Direction buttons, active-high (Down, Up, Left, Right) |
| allow_opposing | input | 1 | 1 disables opposing-direction masking |
| ctrl_req | input | 2 | Controller-request value used when no group is selected |
| irq | output | 1 | One-cycle keypad interrupt request |

## Verification
A corrupted select register shows up on the very next read of 0xFF00: bits 5:4 echo the stored bits directly, and the nibble reflects the wrong group. A scan error, such as a swapped key position, missed masking or a wrong idle subtraction, appears in the nibble of the read issued in the same cycle as the stimulus.

A stale copy of the previous nibble inside the edge detector shows as a missing interrupt pulse, a repeated pulse, or a pulse one cycle late. Each of these is visible on `irq` within two cycles of a key change.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int GROUP_N  = 2;
  localparam logic [ADDR_W-1:0] KEY_REG_ADDR = 16'hFF00;
  localparam logic [NIB_W-1:0]  NIB_IDLE     = 4'hF;
  // select bit positions inside the data byte
  localparam int SEL_ACT_BIT = 5;
  localparam int SEL_DIR_BIT = 4;
  // direction key positions
  localparam int DIR_DOWN  = 3;
  localparam int DIR_UP    = 2;
  localparam int DIR_LEFT  = 1;
  localparam int DIR_RIGHT = 0;
endpackage

// File: rtl/kp_select_reg.sv
module kp_select_reg
  import kp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] REG_ADDR = KEY_REG_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    sel_in,
  output logic [1:0]    sel_q
);
  logic hit;
  assign hit = wr_en && (addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)      sel_q <= 2'b11;
    else if (hit) sel_q <= sel_in;
  end
endmodule

// File: rtl/kp_scan.sv
module kp_scan
  import kp_pkg::*;
#(
  parameter int REQ_W = 2
) (
  input  logic [NIB_W-1:0] act_keys,
  input  logic [NIB_W-1:0] dir_keys,
  input  logic             allow_opposing,
  input  logic [1:0]       sel,        // [1]=action select, [0]=direction select, active-low
  input  logic [REQ_W-1:0] ctrl_req,
  output logic [NIB_W-1:0] nib
);
  localparam int WIDE_W = REQ_W + NIB_W;

  logic [NIB_W-1:0] dir_clean;
  logic [NIB_W-1:0] grp_low [GROUP_N];
  logic [WIDE_W-1:0] req_wide;
  logic [NIB_W-1:0] idle_val;

  // opposing-pair masking: pair 0 keeps Up over Down, pair 1 keeps Left over Right
  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_pair
      localparam int KEEP = (p == 0) ? DIR_UP   : DIR_LEFT;
      localparam int DROP = (p == 0) ? DIR_DOWN : DIR_RIGHT;
      assign dir_clean[KEEP] = dir_keys[KEEP];
      assign dir_clean[DROP] = dir_keys[DROP] & (allow_opposing | ~dir_keys[KEEP]);
    end
  endgenerate

  // per-group active-low contribution, all-ones when the group is deselected
  genvar g;
  generate
    for (g = 0; g < GROUP_N; g++) begin : g_grp
      if (g == 0) begin : g_dir
        assign grp_low[g] = sel[0] ? NIB_IDLE : ~dir_clean;
      end else begin : g_act
        assign grp_low[g] = sel[1] ? NIB_IDLE : ~act_keys;
      end
    end
  endgenerate

  assign req_wide = {{NIB_W{1'b0}}, ctrl_req};

  always_comb begin
    if (req_wide > WIDE_W'(NIB_IDLE)) idle_val = '0;
    else                              idle_val = NIB_IDLE - req_wide[NIB_W-1:0];
  end

  always_comb begin
    if (sel == 2'b11) nib = idle_val;
    else              nib = grp_low[0] & grp_low[1];
  end
endmodule

// File: rtl/kp_irq.sv
module kp_irq
  import kp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] nib,
  output logic [NIB_W-1:0] nib_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nib_q <= NIB_IDLE;
      irq   <= 1'b0;
    end else begin
      nib_q <= nib;
      irq   <= (nib != NIB_IDLE) && (nib_q == NIB_IDLE);
    end
  end
endmodule

// File: rtl/keypad_matrix_reg.sv
module keypad_matrix_reg
  import kp_pkg::*;
#(
  parameter int REQ_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NIB_W-1:0]  act_keys,
  input  logic [NIB_W-1:0]  dir_keys,
  input  logic              allow_opposing,
  input  logic [REQ_W-1:0]  ctrl_req,
  output logic              irq
);
  logic [1:0]       sel_q;
  logic [NIB_W-1:0] scan_nib;
  logic [NIB_W-1:0] scan_q;
  logic             rd_hit;

  kp_select_reg #(.AW(ADDR_W), .REG_ADDR(KEY_REG_ADDR)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .sel_in ({wr_data[SEL_ACT_BIT], wr_data[SEL_DIR_BIT]}),
    .sel_q  (sel_q)
  );

  kp_scan #(.REQ_W(REQ_W)) u_scan (
    .act_keys       (act_keys),
    .dir_keys       (dir_keys),
    .allow_opposing (allow_opposing),
    .sel            (sel_q),
    .ctrl_req       (ctrl_req),
    .nib            (scan_nib)
  );

  kp_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .nib   (scan_nib),
    .nib_q (scan_q),
    .irq   (irq)
  );

  assign rd_hit = (addr == KEY_REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '1;
    else if (rd_en)  rd_data <= rd_hit ? {2'b11, sel_q, scan_nib} : '1;
  end
endmodule

// File: rtl/keypad_matrix_chk.sv
module keypad_matrix_chk
  import kp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        sel_q,
  input logic [NIB_W-1:0]  scan_q,
  input logic              irq
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sel_q == 2'b11 && !irq && rd_data == 8'hFF));

  // R2
  read_format_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == KEY_REG_ADDR) |=> (rd_data[7:6] == 2'b11 && rd_data[5:4] == $past(sel_q)));

  // R3
  sel_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == KEY_REG_ADDR) |=> (sel_q == $past({wr_data[5], wr_data[4]})));

  // R11
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == KEY_REG_ADDR) |=> $stable(sel_q));

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != KEY_REG_ADDR) |=> (rd_data == 8'hFF));

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R10
  irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (scan_q != NIB_IDLE && $past(scan_q) == NIB_IDLE));
endmodule

bind keypad_matrix_reg keypad_matrix_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .sel_q   (sel_q),
  .scan_q  (scan_q),
  .irq     (irq)
);

// File: tb/keypad_matrix_reg_bench.sv
module keypad_matrix_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [3:0]  act_keys = 4'h0;
  logic [3:0]  dir_keys = 4'h0;
  logic        allow_opposing = 1'b0;
  logic [1:0]  ctrl_req = 2'd0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keypad_matrix_reg u_keypad_matrix_reg (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .act_keys(act_keys), .dir_keys(dir_keys),
    .allow_opposing(allow_opposing), .ctrl_req(ctrl_req), .irq(irq)
  );

  // vector: sel[1:0] (bit5,bit4), allow, req[1:0], act[3:0], dir[3:0], exp_nib[3:0], rtag[3:0]
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {2'b01, 1'b0, 2'd0, 4'b0001, 4'b0000, 4'hE, 4'd4}, // R4 A
    {2'b01, 1'b0, 2'd0, 4'b1000, 4'b0000, 4'h7, 4'd4}, // R4 Start
    {2'b01, 1'b0, 2'd0, 4'b0000, 4'b1111, 4'hF, 4'd4}, // R4 dir ignored
    {2'b10, 1'b0, 2'd0, 4'b0000, 4'b0100, 4'hB, 4'd5}, // R5 Up
    {2'b10, 1'b0, 2'd0, 4'b1111, 4'b0001, 4'hE, 4'd5}, // R5 Right, act ignored
    {2'b00, 1'b0, 2'd0, 4'b0010, 4'b0001, 4'hC, 4'd6}, // R6 B and Right
    {2'b00, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'hF, 4'd6}, // R6 nothing
    {2'b10, 1'b0, 2'd0, 4'b0000, 4'b1100, 4'hB, 4'd7}, // R7 up masks down
    {2'b10, 1'b0, 2'd0, 4'b0000, 4'b0011, 4'hD, 4'd7}, // R7 left masks right
    {2'b10, 1'b1, 2'd0, 4'b0000, 4'b1100, 4'h3, 4'd8}, // R8
    {2'b10, 1'b1, 2'd0, 4'b0000, 4'b0011, 4'hC, 4'd8}, // R8
    {2'b11, 1'b0, 2'd2, 4'b1111, 4'b1111, 4'hD, 4'd9}, // R9
    {2'b11, 1'b0, 2'd3, 4'b0000, 4'b0000, 4'hC, 4'd9}  // R9
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  initial begin
    logic [7:0] r;
    int pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq", {7'd0, irq}, 8'h00);
    bus_read(16'hFF00, r);
    check("R1 reset read", r, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      logic [7:0] ex;
      v = VEC[i];
      bus_write(16'hFF00, {2'b00, v[20:19], 4'h0});
      allow_opposing = v[18]; ctrl_req = v[17:16];
      act_keys = v[15:12]; dir_keys = v[11:8];
      ex = {2'b11, v[20:19], v[7:4]};
      bus_read(16'hFF00, r);
      check($sformatf("R%0d R2 vector %0d", v[3:0], i), r, ex);
      act_keys = 4'h0; dir_keys = 4'h0; allow_opposing = 1'b0; ctrl_req = 2'd0;
    end

    // R3: only bits 5:4 stored
    bus_write(16'hFF00, 8'hCF);
    bus_read(16'hFF00, r);
    check("R3 write CF", r, 8'hCF);
    bus_write(16'hFF00, 8'h30);
    bus_read(16'hFF00, r);
    check("R3 write 30", r, 8'hFF);

    // R11
    bus_read(16'hFF01, r);
    check("R11 unmapped read", r, 8'hFF);
    bus_write(16'hFF01, 8'h00);
    bus_read(16'hFF00, r);
    check("R11 unmapped write", r, 8'hFF);

    // R10: pulse on release->press, once while held
    bus_write(16'hFF00, 8'h10);            // action group selected
    repeat (2) @(negedge clk);
    check("R10 idle", {7'd0, irq}, 8'h00);
    act_keys = 4'b0001;
    @(negedge clk);
    check("R10 pulse", {7'd0, irq}, 8'h01);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    check("R10 held no refire", 8'(pulses), 8'h00);
    act_keys = 4'b0000;
    repeat (2) @(negedge clk);
    act_keys = 4'b0100;
    @(negedge clk);
    check("R10 second press", {7'd0, irq}, 8'h01);
    @(negedge clk);
    check("R10 pulse width", {7'd0, irq}, 8'h00);
    act_keys = 4'b0000;

    // R1 again mid-run
    bus_write(16'hFF00, 8'h00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_read(16'hFF00, r);
    check("R1 reset restores select", r, 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule